// File: doc/BRIEF.md
# Two-Stage Gated Clock Divider

This block derives a slower clock from `clk_in`. It divides the input clock by a power of two and then by a linear factor. It can also apply a fixed extra factor, chosen when the block is built, and a run-time factor of two. One control word holds all the settings: a gate bit, a mode bit that halves the output rate, a linear divider field and an exponent field.

The control word can be written in two ways. A full-word write replaces every bit. A divider update takes the desired linear divider and the desired power-of-two divider as plain values. It encodes them into their fields and leaves every other bit of the word unchanged.

A new setting reaches the output only when the current output period ends, so the output never shows a shortened pulse. While the gate is off, the output is held low. The programmed word, the gate state and the total division that the word selects can all be read back at the ports.

Top module: `mp_clock_divider`

## Requirements
- R1: After reset the control word reads as `RST_WORD` (default zero), `gate_on` is 0 and `clk_out` is low.
- R2: A full-word write (`cfg_we`) replaces the whole control word, which `cfg_rdata` shows from the next cycle on. `gate_on` mirrors control bit `GATE_BIT` (default 31).
- R3: A divider update (`div_we`) with `cfg_we` low changes two fields and nothing else. The linear field, bits `[M_LSB +: M_W]` (default [3:0]), becomes `div_m - M_OFFSET`. The exponent field, bits `[P_LSB +: P_W]` (default [17:16]), becomes the index of the highest set bit of `div_pow`, or 0 when `div_pow` is zero. When both write strobes are high in one cycle, the full-word write wins.
- R4: The effective linear divider is the linear field plus `M_OFFSET`. A sum of zero is used as one.
- R5: `total_div` equals `M_eff * 2^P`, multiplied by `POST_DIV` when `POST_EN` is set and doubled when mode bit `MODE_BIT` (default 30) is 1.
- R6: While the gate is on, `clk_out` repeats with a period of N = total division input cycles. Each period is high for ceil(N/2) cycles and then low for floor(N/2) cycles, so an even N gives 50% duty. When N is 1, the output follows `clk_in`.
- R7: While the gate is off, `clk_out` stays low. Clearing the gate lets the high phase in progress finish at its full length before the output stays low.
- R8: A change to the divider settings written during an output period takes effect only after that period completes. The period in progress keeps its old high and low lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Full control word write strobe |
| cfg_wdata | input | CW | Control word to write |
| div_we | input | 1 | Divider field update strobe |
| div_m | input | M_W+1 | Desired linear divider value |
| div_pow | input | 2**P_W | Desired power-of-two divider value (one-hot) |
| cfg_rdata | output | CW | Current control word |
| gate_on | output | 1 | Programmed gate state |
| total_div | output | TD_W | Total division selected by the control word |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
The bench builds the block with `M_OFFSET` set to 0. With that value an all-zero linear field yields a divider sum of zero, which brings the zero-means-one rule within reach. It also enables the post-divide with `POST_DIV` set to 3. This makes odd totals such as 9 reachable, so the uneven high/low split is exercised, and it checks that the readback folds in both the post factor and the mode doubling. The remaining parameters keep their defaults, so the field positions checked by the read-modify-write tests are bits [3:0], [17:16], 30 and 31.

// File: rtl/mdiv_pkg.sv
`timescale 1ns/1ps
package mdiv_pkg;

   // Source selected for the next value of the control word.
   typedef enum logic [1:0] {
      SRC_HOLD   = 2'd0,
      SRC_WORD   = 2'd1,
      SRC_FIELDS = 2'd2
   } wr_src_e;

   // Width of the total-division value for a given configuration.
   function automatic int unsigned total_width(int unsigned m_w, int unsigned p_w,
                                               int unsigned post_div);
      return (m_w + 1) + ((1 << p_w) - 1) + $clog2(post_div + 1) + 1;
   endfunction

endpackage

// File: rtl/mdiv_ctrl_reg.sv
`timescale 1ns/1ps
module mdiv_ctrl_reg
   import mdiv_pkg::*;
#(
   parameter int          CW       = 32,
   parameter int          M_LSB    = 0,
   parameter int          M_W      = 4,
   parameter int          P_LSB    = 16,
   parameter int          P_W      = 2,
   parameter int          M_OFFSET = 1,
   parameter logic [CW-1:0] RST_WORD = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [CW-1:0]         cfg_wdata,
   input  logic                  div_we,
   input  logic [M_W:0]          div_m,
   input  logic [(2**P_W)-1:0]   div_pow,
   output logic [CW-1:0]         ctrl_q
);

   localparam int PV_W = 2 ** P_W;
   localparam logic [CW-1:0] M_MASK = {{(CW-M_W){1'b0}}, {M_W{1'b1}}} << M_LSB;
   localparam logic [CW-1:0] P_MASK = {{(CW-P_W){1'b0}}, {P_W{1'b1}}} << P_LSB;
   localparam logic [CW-1:0] F_MASK = M_MASK | P_MASK;

   wr_src_e         src;
   logic [M_W:0]    m_diff;
   logic [M_W-1:0]  m_field;
   logic [P_W-1:0]  p_exp;
   logic [CW-1:0]   field_word;
   logic [CW-1:0]   ctrl_d;

   // A full-word write has priority over a field update.
   always_comb begin
      if (cfg_we)
         src = SRC_WORD;
      else if (div_we)
         src = SRC_FIELDS;
      else
         src = SRC_HOLD;
   end

   // Linear field stores the requested divider minus the offset.
   assign m_diff  = div_m - (M_W+1)'(M_OFFSET);
   assign m_field = m_diff[M_W-1:0];

   // Exponent is the position of the highest set bit of the requested power.
   always_comb begin
      p_exp = '0;
      for (int i = 0; i < PV_W; i++) begin
         if (div_pow[i])
            p_exp = P_W'(i);
      end
   end

   assign field_word = (ctrl_q & ~F_MASK)
                     | ((CW'(m_field) << M_LSB) & M_MASK)
                     | ((CW'(p_exp)   << P_LSB) & P_MASK);

   always_comb begin
      unique case (src)
         SRC_WORD:   ctrl_d = cfg_wdata;
         SRC_FIELDS: ctrl_d = field_word;
         default:    ctrl_d = ctrl_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= RST_WORD;
      else
         ctrl_q <= ctrl_d;
   end

   // R3
   field_only_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_we && !cfg_we) |=> (((ctrl_q ^ $past(ctrl_q)) & ~F_MASK) == '0));

   // R2
   word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (ctrl_q == $past(cfg_wdata)));

endmodule

// File: rtl/mdiv_ratio_calc.sv
`timescale 1ns/1ps
module mdiv_ratio_calc #(
   parameter int M_W      = 4,
   parameter int P_W      = 2,
   parameter int M_OFFSET = 1,
   parameter bit POST_EN  = 1'b0,
   parameter int POST_DIV = 1,
   parameter int TD_W     = 10
) (
   input  logic [M_W-1:0]  m_fld,
   input  logic [P_W-1:0]  p_fld,
   input  logic            mode_half,
   output logic [TD_W-1:0] total
);

   localparam int MV_W = M_W + 1;

   logic [MV_W-1:0] m_sum;
   logic [MV_W-1:0] m_eff;
   logic [TD_W-1:0] scaled;
   logic [TD_W-1:0] posted;

   // Linear divider: field plus offset, with a zero result used as one.
   assign m_sum  = MV_W'(m_fld) + MV_W'(M_OFFSET);
   assign m_eff  = (m_sum == '0) ? MV_W'(1) : m_sum;

   // Power-of-two stage applied as a shift.
   assign scaled = TD_W'(m_eff) << p_fld;

   generate
      if (POST_EN) begin : g_post
         assign posted = scaled * TD_W'(POST_DIV);
      end else begin : g_no_post
         assign posted = scaled;
      end
   endgenerate

   // Timing mode halves the output, i.e. doubles the division.
   assign total = mode_half ? (posted << 1) : posted;

   // R4
   always_comb begin
      if (!$isunknown(m_fld)) begin
         m_eff_nonzero_chk: assert (m_eff != '0);
      end
   end

endmodule

// File: rtl/mdiv_clk_gen.sv
`timescale 1ns/1ps
module mdiv_clk_gen #(
   parameter int TD_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TD_W-1:0] n_pend,
   input  logic            gate_pend,
   output logic            clk_out
);

   logic [TD_W-1:0] act_n_q;
   logic            act_gate_q;
   logic [TD_W-1:0] cnt_q;
   logic            out_q;

   logic            boundary;
   logic [TD_W-1:0] n_nx;
   logic            gate_nx;
   logic [TD_W-1:0] cnt_nx;
   logic [TD_W:0]   hi_nx;
   logic            out_nx;
   logic            bypass;

   // A period ends on its last count; while gated off every cycle is a boundary.
   assign boundary = !act_gate_q || (cnt_q == act_n_q - TD_W'(1));

   always_comb begin
      if (boundary) begin
         n_nx    = n_pend;
         gate_nx = gate_pend;
         cnt_nx  = '0;
      end else begin
         n_nx    = act_n_q;
         gate_nx = act_gate_q;
         cnt_nx  = cnt_q + TD_W'(1);
      end
      hi_nx  = ({1'b0, n_nx} + (TD_W+1)'(1)) >> 1;
      out_nx = gate_nx && ({1'b0, cnt_nx} < hi_nx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_n_q    <= TD_W'(1);
         act_gate_q <= 1'b0;
         cnt_q      <= '0;
         out_q      <= 1'b0;
      end else begin
         act_n_q    <= n_nx;
         act_gate_q <= gate_nx;
         cnt_q      <= cnt_nx;
         out_q      <= out_nx;
      end
   end

   // Division by one passes the input clock through while enabled.
   assign bypass  = (act_n_q == TD_W'(1));
   assign clk_out = bypass ? (clk & out_q) : out_q;

   // R6
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < act_n_q);

   // R6
   rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_q) |-> (cnt_q == '0));

   // R8
   hold_mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> ($stable(act_n_q) && $stable(act_gate_q)));

   // R7
   gate_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !gate_pend) |=> !out_q);

endmodule

// File: rtl/mp_clock_divider.sv
`timescale 1ns/1ps
module mp_clock_divider
   import mdiv_pkg::*;
#(
   parameter int            CW       = 32,
   parameter int            M_LSB    = 0,
   parameter int            M_W      = 4,
   parameter int            P_LSB    = 16,
   parameter int            P_W      = 2,
   parameter int            MODE_BIT = 30,
   parameter int            GATE_BIT = 31,
   parameter int            M_OFFSET = 1,
   parameter bit            POST_EN  = 1'b0,
   parameter int            POST_DIV = 1,
   parameter logic [CW-1:0] RST_WORD = '0,
   localparam int           TD_W     = total_width(M_W, P_W, POST_DIV)
) (
   input  logic                 clk_in,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CW-1:0]        cfg_wdata,
   input  logic                 div_we,
   input  logic [M_W:0]         div_m,
   input  logic [(2**P_W)-1:0]  div_pow,
   output logic [CW-1:0]        cfg_rdata,
   output logic                 gate_on,
   output logic [TD_W-1:0]      total_div,
   output logic                 clk_out
);

   // Elaboration-time parameter checks.
   generate
      if (M_W < 1 || P_W < 1) begin : g_bad_width
         $error("divider field widths must be at least one bit");
      end
      if (M_LSB + M_W > CW || P_LSB + P_W > CW) begin : g_bad_span
         $error("divider fields must fit in the control word");
      end
      if ((P_LSB < M_LSB + M_W) && (M_LSB < P_LSB + P_W)) begin : g_overlap
         $error("linear and exponent fields overlap");
      end
      if (MODE_BIT >= CW || GATE_BIT >= CW || MODE_BIT == GATE_BIT) begin : g_bad_bits
         $error("mode and gate bits must be distinct and inside the word");
      end
      if ((MODE_BIT >= M_LSB && MODE_BIT < M_LSB + M_W) ||
          (MODE_BIT >= P_LSB && MODE_BIT < P_LSB + P_W) ||
          (GATE_BIT >= M_LSB && GATE_BIT < M_LSB + M_W) ||
          (GATE_BIT >= P_LSB && GATE_BIT < P_LSB + P_W)) begin : g_bit_clash
         $error("mode or gate bit falls inside a divider field");
      end
      if (M_OFFSET < 0 || M_OFFSET > 1) begin : g_bad_offset
         $error("linear offset must be 0 or 1");
      end
      if (POST_DIV < 1) begin : g_bad_post
         $error("post-divide factor must be at least one");
      end
   endgenerate

   logic [CW-1:0]   ctrl_q;
   logic [TD_W-1:0] n_sel;

   mdiv_ctrl_reg #(
      .CW       (CW),
      .M_LSB    (M_LSB),
      .M_W      (M_W),
      .P_LSB    (P_LSB),
      .P_W      (P_W),
      .M_OFFSET (M_OFFSET),
      .RST_WORD (RST_WORD)
   ) u_ctrl (
      .clk       (clk_in),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .div_we    (div_we),
      .div_m     (div_m),
      .div_pow   (div_pow),
      .ctrl_q    (ctrl_q)
   );

   mdiv_ratio_calc #(
      .M_W      (M_W),
      .P_W      (P_W),
      .M_OFFSET (M_OFFSET),
      .POST_EN  (POST_EN),
      .POST_DIV (POST_DIV),
      .TD_W     (TD_W)
   ) u_ratio (
      .m_fld     (ctrl_q[M_LSB +: M_W]),
      .p_fld     (ctrl_q[P_LSB +: P_W]),
      .mode_half (ctrl_q[MODE_BIT]),
      .total     (n_sel)
   );

   mdiv_clk_gen #(
      .TD_W (TD_W)
   ) u_gen (
      .clk       (clk_in),
      .rst_n     (rst_n),
      .n_pend    (n_sel),
      .gate_pend (ctrl_q[GATE_BIT]),
      .clk_out   (clk_out)
   );

   assign cfg_rdata = ctrl_q;
   assign gate_on   = ctrl_q[GATE_BIT];
   assign total_div = n_sel;

   // R5
   total_nonzero_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      total_div != '0);

   // R5
   mode_doubles_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      ($rose(ctrl_q[MODE_BIT]) && $stable(ctrl_q[M_LSB +: M_W]) &&
       $stable(ctrl_q[P_LSB +: P_W])) |-> (total_div == ($past(total_div) << 1)));

endmodule

// File: tb/tb_mp_clock_divider.sv
`timescale 1ns/1ps
module tb_mp_clock_divider;

   localparam int CLK_PERIOD = 8;
   localparam int CW   = 32;
   localparam int M_W  = 4;
   localparam int P_W  = 2;
   localparam int PDIV = 3;
   localparam int TD_W = (M_W + 1) + ((1 << P_W) - 1) + $clog2(PDIV + 1) + 1;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                cfg_we = 1'b0;
   logic [CW-1:0]       cfg_wdata = '0;
   logic                div_we = 1'b0;
   logic [M_W:0]        div_m = '0;
   logic [(2**P_W)-1:0] div_pow = '0;
   logic [CW-1:0]       cfg_rdata;
   logic                gate_on;
   logic [TD_W-1:0]     total_div;
   logic                clk_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mp_clock_divider #(
      .M_OFFSET (0),
      .POST_EN  (1'b1),
      .POST_DIV (PDIV)
   ) dut (
      .clk_in    (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .div_we    (div_we),
      .div_m     (div_m),
      .div_pow   (div_pow),
      .cfg_rdata (cfg_rdata),
      .gate_on   (gate_on),
      .total_div (total_div),
      .clk_out   (clk_out)
   );

   function automatic logic [CW-1:0] mk(bit g, bit md, int m, int p);
      logic [CW-1:0] w = '0;
      w[31]    = g;
      w[30]    = md;
      w[3:0]   = m[3:0];
      w[17:16] = p[1:0];
      return w;
   endfunction

   function automatic int exp_n(bit md, int m, int p);
      int me = (m == 0) ? 1 : m;
      return me * (1 << p) * PDIV * (md ? 2 : 1);
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Advance to a quarter period after the next rising edge; strobes drop there.
   task automatic step();
      @(posedge clk);
      #(CLK_PERIOD/4);
      cfg_we = 1'b0;
      div_we = 1'b0;
   endtask

   task automatic write_word(logic [CW-1:0] w);
      cfg_we = 1'b1;
      cfg_wdata = w;
      step();
   endtask

   task automatic write_fields(int m, int pw);
      div_we = 1'b1;
      div_m = (M_W+1)'(m);
      div_pow = (2**P_W)'(pw);
      step();
   endtask

   task automatic wait_rise(string req);
      bit prev = clk_out;
      for (int i = 0; i < 3000; i++) begin
         step();
         if (!prev && clk_out) return;
         prev = clk_out;
      end
      chk(1'b0, req, "no rising edge on clk_out", 0, 1);
   endtask

   // Starts at the sample where clk_out just rose; ends at the next rise.
   task automatic count_period(output int hi, output int lo);
      hi = 0;
      lo = 0;
      while (clk_out && hi < 3000) begin
         hi++;
         step();
      end
      while (!clk_out && lo < 3000) begin
         lo++;
         step();
      end
   endtask

   task automatic t_reset();
      chk(cfg_rdata == '0, "R1", "reset word", cfg_rdata, 0);
      chk(gate_on == 1'b0, "R1", "reset gate", gate_on, 0);
      // R4: all-zero linear field with zero offset counts as one
      chk(total_div == TD_W'(exp_n(0, 0, 0)), "R4", "zero field total", total_div, exp_n(0, 0, 0));
      begin
         int highs = 0;
         for (int i = 0; i < 10; i++) begin
            step();
            if (clk_out) highs++;
         end
         chk(highs == 0, "R1", "clk_out high after reset", highs, 0);
      end
   endtask

   task automatic t_full_write();
      int hi, lo;
      write_word(mk(1, 0, 4, 1));
      chk(cfg_rdata == mk(1, 0, 4, 1), "R2", "word readback", cfg_rdata, mk(1, 0, 4, 1));
      chk(gate_on == 1'b1, "R2", "gate readback", gate_on, 1);
      chk(total_div == TD_W'(24), "R5", "total 4*2*3", total_div, 24);
      wait_rise("R6");
      count_period(hi, lo);
      chk(hi == 12, "R6", "even high", hi, 12);
      chk(lo == 12, "R6", "even low", lo, 12);
   endtask

   task automatic t_odd();
      int hi, lo;
      write_word(mk(1, 0, 3, 0));
      chk(total_div == TD_W'(9), "R5", "total 3*1*3", total_div, 9);
      wait_rise("R6");
      wait_rise("R6");
      count_period(hi, lo);
      chk(hi == 5, "R6", "odd high", hi, 5);
      chk(lo == 4, "R6", "odd low", lo, 4);
   endtask

   task automatic t_mode();
      int hi, lo;
      write_word(mk(1, 1, 5, 0));
      chk(total_div == TD_W'(30), "R5", "mode doubles total", total_div, 30);
      wait_rise("R5");
      wait_rise("R5");
      count_period(hi, lo);
      chk(hi == 15 && lo == 15, "R5", "mode period high", hi, 15);
      chk(lo == 15, "R6", "mode period low", lo, 15);
   endtask

   task automatic t_fields();
      logic [CW-1:0] w0 = 32'h2ABC_5FF7;
      logic [CW-1:0] expw;
      write_word(w0);
      write_fields(6, 4);
      expw = (w0 & ~32'h0003_000F) | 32'h0002_0006;
      chk(cfg_rdata == expw, "R3", "field update keeps other bits", cfg_rdata, expw);
      chk(total_div == TD_W'(72), "R5", "total 6*4*3", total_div, 72);
      write_fields(0, 8);
      expw = (w0 & ~32'h0003_000F) | 32'h0003_0000;
      chk(cfg_rdata == expw, "R3", "exponent from pow 8", cfg_rdata, expw);
      chk(total_div == TD_W'(24), "R4", "zero field as one", total_div, 24);
      write_fields(15, 1);
      expw = (w0 & ~32'h0003_000F) | 32'h0000_000F;
      chk(cfg_rdata == expw, "R3", "exponent from pow 1", cfg_rdata, expw);
      // R3: both strobes, full word wins
      cfg_we = 1'b1;
      cfg_wdata = 32'h1234_0009;
      div_we = 1'b1;
      div_m = 5'd2;
      div_pow = 4'd2;
      step();
      chk(cfg_rdata == 32'h1234_0009, "R3", "word write priority", cfg_rdata, 32'h1234_0009);
   endtask

   task automatic t_gate();
      int hi = 0;
      int highs = 0;
      write_word(mk(1, 0, 2, 1));
      wait_rise("R7");
      wait_rise("R7");
      cfg_we = 1'b1;
      cfg_wdata = mk(0, 0, 2, 1);
      while (clk_out && hi < 100) begin
         hi++;
         step();
      end
      chk(hi == 6, "R7", "high phase kept on gate off", hi, 6);
      chk(gate_on == 1'b0, "R2", "gate readback off", gate_on, 0);
      for (int i = 0; i < 40; i++) begin
         step();
         if (clk_out) highs++;
      end
      chk(highs == 0, "R7", "clk_out high while gated", highs, 0);
      chk(total_div == TD_W'(12), "R5", "total while gated", total_div, 12);
   endtask

   task automatic t_boundary();
      int hi, lo;
      write_word(mk(1, 0, 4, 1));
      wait_rise("R8");
      wait_rise("R8");
      cfg_we = 1'b1;
      cfg_wdata = mk(1, 0, 2, 0);
      count_period(hi, lo);
      chk(hi == 12, "R8", "old high kept", hi, 12);
      chk(lo == 12, "R8", "old low kept", lo, 12);
      count_period(hi, lo);
      chk(hi == 3 && lo == 3, "R8", "new period high", hi, 3);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL R6 watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD/4);
      repeat (3) @(posedge clk);
      #(CLK_PERIOD/4);
      rst_n = 1'b1;
      t_reset();
      t_full_write();
      t_odd();
      t_mode();
      t_fields();
      t_gate();
      t_boundary();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule